// File: doc/BRIEF.md
# Dirty-Band Display Update Tracker

The tracker watches writes into frame memory and keeps one dirty flag per memory page. Each page of the indexed (one byte per pixel) plane holds a horizontal band of display lines, four lines by default. When a refresh is requested, the tracker walks the bands from the top of the screen downwards. It merges every unbroken run of dirty bands into one update rectangle and hands that rectangle to the display side as a first line and a line count. When the walk is over, it clears the flags it has consumed and raises a done pulse. Every rectangle spans the whole screen width from column zero, so the rectangle carries only its vertical extent.

Frame memory holds three planes. The indexed plane has one page per band. The direct-colour plane and the per-pixel control plane each have four pages per band. In deep-colour mode a band also counts as dirty when any of its four pages in either of the wide planes is dirty. In indexed mode the wide planes are tracked but take no part in the walk. An invalidate command marks every page of every plane dirty, so that the next refresh redraws the whole screen.

Top module: `dirty_band_tracker`

## Requirements
- R1: A snoop write with plane code 0 (indexed) sets the flag of band `addr >> PAGE_SHIFT`. Plane codes 1 (direct) and 2 (control) set the flag of page `addr >> PAGE_SHIFT` of that plane, and page p belongs to band p/4. Plane code 3, and any page beyond the plane's size, change no flag.
- R2: A refresh visits bands 0, 1, 2 ... in ascending order. It covers ceil(height/LINES_PER_BAND) bands, limited to NUM_BANDS, and height is sampled on the start pulse.
- R3: Each maximal run of dirty bands from band s up to band e-1 gives exactly one rectangle, with rectY = s*LINES_PER_BAND and rectH = (e-s)*LINES_PER_BAND. A run still open at the last visited band closes at the band limit. Rectangles come out in ascending order, and rectH is never zero.
- R4: With deepMode = 1 sampled at start, a band is dirty if its indexed flag or any of its four direct or four control page flags is set. With deepMode = 0 only the indexed flag counts.
- R5: After the walk, if any band was dirty, the indexed flags of every band from the lowest to the highest dirty band are cleared, including clean bands between runs. In deep mode the direct and control pages 4*lowest up to 4*highest+3 are cleared as well. When no band was dirty, nothing is cleared.
- R6: A one-cycle invalidate sets every flag in all three planes.
- R7: While rectValid = 1 and rectReady = 0, rectValid stays high and rectY and rectH hold their values. The walk does not advance until the rectangle is taken.
- R8: When a snoop write and the end-of-walk clear hit the same page in the same cycle, the page stays dirty.
- R9: done is high for exactly one cycle at the end of each walk, and never while rectValid is high. A start pulse that arrives while a walk is in progress is ignored.
- R10: After reset no rectangle is pending, done is low and every flag is clear, so a refresh then yields no rectangle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snoopValid | input | 1 | A frame-memory write is present this cycle |
| snoopPlane | input | 2 | Plane of the write: 0 indexed, 1 direct, 2 control, 3 none |
| snoopAddr | input | ADDR_W | Byte offset of the write inside its plane |
| invalidate | input | 1 | Mark every page of every plane dirty |
| deepMode | input | 1 | Include the wide planes in the walk (sampled on start) |
| height | input | LINE_W | Display height in lines (sampled on start) |
| start | input | 1 | Begin a refresh walk (ignored when busy) |
| rectValid | output | 1 | An update rectangle is offered |
| rectReady | input | 1 | The display side takes the offered rectangle |
| rectY | output | LINE_W | First line of the rectangle |
| rectH | output | LINE_W | Number of lines in the rectangle |
| done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The bench builds the tracker with NUM_BANDS = 8, PAGE_SHIFT = 4 and ADDR_W = 10. At these values each page is 16 bytes, the wide planes have 32 pages, and random addresses often fall past the end of a plane. With only eight bands, random writes readily produce runs that touch the top band, the bottom band, or both. The same values let heights beyond the band limit and heights that are not a multiple of four be checked in a few cycles. The 6-bit line fields reach the full 32-line screen.

// File: rtl/tracker_pkg.sv
package tracker_pkg;

  localparam int SUB_PAGES = 4;

  localparam logic [1:0] PLANE_INDEXED = 2'd0;
  localparam logic [1:0] PLANE_DIRECT  = 2'd1;
  localparam logic [1:0] PLANE_CONTROL = 2'd2;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SCAN  = 2'd1,
    S_EMIT  = 2'd2,
    S_CLEAR = 2'd3
  } scan_state_t;

  // strobes from the walk control to the flag store
  typedef struct packed {
    logic clearRange;
    logic deepSel;
  } store_ctl_t;

endpackage

// File: rtl/band_dirty_store.sv
module band_dirty_store
  import tracker_pkg::*;
#(
  parameter int NUM_BANDS  = 192,
  parameter int ADDR_W     = 24,
  parameter int PAGE_SHIFT = 12,
  parameter int BAND_W     = $clog2(NUM_BANDS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snoopValid,
  input  logic [1:0]        snoopPlane,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              invalidate,
  input  store_ctl_t        ctl,
  input  logic [BAND_W-1:0] bandIdx,
  input  logic [BAND_W-1:0] clrLo,
  input  logic [BAND_W-1:0] clrHi,
  output logic              bandDirty
);

  localparam int DEEP_PAGES = NUM_BANDS * SUB_PAGES;
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int PAD_W      = 2 ** BAND_W;

  logic [NUM_BANDS-1:0]  idxBits, idxSet, idxClr, bandVec;
  logic [DEEP_PAGES-1:0] dirBits, dirSet, dirClr;
  logic [DEEP_PAGES-1:0] ctlBits, ctlSet, ctlClr;
  logic [PAGE_W-1:0]     snoopPage;
  logic [PAD_W-1:0]      bandPad;
  logic                  unusedLowBits;

  assign snoopPage     = snoopAddr[ADDR_W-1:PAGE_SHIFT];
  assign unusedLowBits = ^snoopAddr[PAGE_SHIFT-1:0];

  generate
    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
      assign idxSet[b] = snoopValid && (snoopPlane == PLANE_INDEXED) &&
                         (snoopPage == PAGE_W'(b));
      assign idxClr[b] = ctl.clearRange && (BAND_W'(b) >= clrLo) &&
                         (BAND_W'(b) <= clrHi);
      assign bandVec[b] = idxBits[b] ||
                          (ctl.deepSel && ((|dirBits[b*SUB_PAGES +: SUB_PAGES]) ||
                                           (|ctlBits[b*SUB_PAGES +: SUB_PAGES])));
    end
    for (genvar p = 0; p < DEEP_PAGES; p++) begin : g_page
      logic inRange;
      assign inRange   = ctl.clearRange && ctl.deepSel &&
                         (BAND_W'(p / SUB_PAGES) >= clrLo) &&
                         (BAND_W'(p / SUB_PAGES) <= clrHi);
      assign dirSet[p] = snoopValid && (snoopPlane == PLANE_DIRECT) &&
                         (snoopPage == PAGE_W'(p));
      assign ctlSet[p] = snoopValid && (snoopPlane == PLANE_CONTROL) &&
                         (snoopPage == PAGE_W'(p));
      assign dirClr[p] = inRange;
      assign ctlClr[p] = inRange;
    end
  endgenerate

  // a set in the same cycle as a clear leaves the flag high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxBits <= '0;
      dirBits <= '0;
      ctlBits <= '0;
    end else if (invalidate) begin
      idxBits <= '1;
      dirBits <= '1;
      ctlBits <= '1;
    end else begin
      idxBits <= (idxBits & ~idxClr) | idxSet;
      dirBits <= (dirBits & ~dirClr) | dirSet;
      ctlBits <= (ctlBits & ~ctlClr) | ctlSet;
    end
  end

  assign bandPad   = PAD_W'(bandVec);
  assign bandDirty = bandPad[bandIdx];

endmodule

// File: rtl/band_scan_ctrl.sv
module band_scan_ctrl
  import tracker_pkg::*;
#(
  parameter int NUM_BANDS      = 192,
  parameter int LINES_PER_BAND = 4,
  parameter int BAND_W         = $clog2(NUM_BANDS + 1),
  parameter int LINE_W         = $clog2(NUM_BANDS * LINES_PER_BAND + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              deepMode,
  input  logic [LINE_W-1:0] height,
  input  logic              bandDirty,
  input  logic              rectReady,
  output logic [BAND_W-1:0] bandIdx,
  output logic [BAND_W-1:0] clrLo,
  output logic [BAND_W-1:0] clrHi,
  output store_ctl_t        ctl,
  output logic              rectValid,
  output logic [LINE_W-1:0] rectY,
  output logic [LINE_W-1:0] rectH,
  output logic              done
);

  localparam int LPB_SHIFT = $clog2(LINES_PER_BAND);

  scan_state_t       state;
  logic [BAND_W-1:0] band, runStart, minBand, maxBand, bandLimit, limitNext;
  logic              inRun, anyDirty, lastRect, deepSel;
  logic [LINE_W:0]   roundUp, bandsNeeded;

  function automatic logic [LINE_W-1:0] lineOf(input logic [BAND_W-1:0] b);
    return LINE_W'(b) << LPB_SHIFT;
  endfunction

  assign roundUp     = {1'b0, height} + (LINE_W + 1)'(LINES_PER_BAND - 1);
  assign bandsNeeded = roundUp >> LPB_SHIFT;
  assign limitNext   = (bandsNeeded > (LINE_W + 1)'(NUM_BANDS)) ?
                       BAND_W'(NUM_BANDS) : BAND_W'(bandsNeeded);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      band      <= '0;
      runStart  <= '0;
      minBand   <= '0;
      maxBand   <= '0;
      bandLimit <= '0;
      inRun     <= 1'b0;
      anyDirty  <= 1'b0;
      lastRect  <= 1'b0;
      deepSel   <= 1'b0;
      rectY     <= '0;
      rectH     <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (start) begin
            state     <= S_SCAN;
            band      <= '0;
            inRun     <= 1'b0;
            anyDirty  <= 1'b0;
            bandLimit <= limitNext;
            deepSel   <= deepMode;
          end
        end
        S_SCAN: begin
          if (band >= bandLimit) begin
            if (inRun) begin
              rectY    <= lineOf(runStart);
              rectH    <= lineOf(band) - lineOf(runStart);
              inRun    <= 1'b0;
              lastRect <= 1'b1;
              state    <= S_EMIT;
            end else begin
              state <= S_CLEAR;
            end
          end else if (bandDirty) begin
            if (!inRun) begin
              inRun    <= 1'b1;
              runStart <= band;
            end
            if (!anyDirty) minBand <= band;
            maxBand  <= band;
            anyDirty <= 1'b1;
            band     <= band + 1'b1;
          end else begin
            band <= band + 1'b1;
            if (inRun) begin
              rectY    <= lineOf(runStart);
              rectH    <= lineOf(band) - lineOf(runStart);
              inRun    <= 1'b0;
              lastRect <= 1'b0;
              state    <= S_EMIT;
            end
          end
        end
        S_EMIT: begin
          if (rectReady) state <= lastRect ? S_CLEAR : S_SCAN;
        end
        S_CLEAR: begin
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bandIdx        = band;
  assign clrLo          = minBand;
  assign clrHi          = maxBand;
  assign ctl.clearRange = (state == S_CLEAR) && anyDirty;
  assign ctl.deepSel    = deepSel;
  assign rectValid      = (state == S_EMIT);
  assign done           = (state == S_CLEAR);

endmodule

// File: rtl/dirty_band_tracker.sv
module dirty_band_tracker
  import tracker_pkg::*;
#(
  parameter int NUM_BANDS      = 192,
  parameter int LINES_PER_BAND = 4,
  parameter int ADDR_W         = 24,
  parameter int PAGE_SHIFT     = 12,
  parameter int LINE_W         = $clog2(NUM_BANDS * LINES_PER_BAND + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              snoopValid,
  input  logic [1:0]        snoopPlane,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic              invalidate,
  input  logic              deepMode,
  input  logic [LINE_W-1:0] height,
  input  logic              start,
  output logic              rectValid,
  input  logic              rectReady,
  output logic [LINE_W-1:0] rectY,
  output logic [LINE_W-1:0] rectH,
  output logic              done
);

  localparam int BAND_W = $clog2(NUM_BANDS + 1);

  store_ctl_t        ctl;
  logic [BAND_W-1:0] bandIdx, clrLo, clrHi;
  logic              bandDirty;

  band_dirty_store #(
    .NUM_BANDS (NUM_BANDS),
    .ADDR_W    (ADDR_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .BAND_W    (BAND_W)
  ) i_store (
    .clk       (clk),
    .rstN      (rstN),
    .snoopValid(snoopValid),
    .snoopPlane(snoopPlane),
    .snoopAddr (snoopAddr),
    .invalidate(invalidate),
    .ctl       (ctl),
    .bandIdx   (bandIdx),
    .clrLo     (clrLo),
    .clrHi     (clrHi),
    .bandDirty (bandDirty)
  );

  band_scan_ctrl #(
    .NUM_BANDS     (NUM_BANDS),
    .LINES_PER_BAND(LINES_PER_BAND),
    .BAND_W        (BAND_W),
    .LINE_W        (LINE_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .deepMode (deepMode),
    .height   (height),
    .bandDirty(bandDirty),
    .rectReady(rectReady),
    .bandIdx  (bandIdx),
    .clrLo    (clrLo),
    .clrHi    (clrHi),
    .ctl      (ctl),
    .rectValid(rectValid),
    .rectY    (rectY),
    .rectH    (rectH),
    .done     (done)
  );

endmodule

// File: rtl/dirty_band_tracker_checker.sv
module dirty_band_tracker_checker #(
  parameter int NUM_BANDS      = 192,
  parameter int LINES_PER_BAND = 4,
  parameter int LINE_W         = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              rectValid,
  input logic              rectReady,
  input logic [LINE_W-1:0] rectY,
  input logic [LINE_W-1:0] rectH,
  input logic              done
);

  // R7: an offered rectangle is held until it is taken
  a_r7_hold_until_taken: assert property (@(posedge clk) disable iff (!rstN)
    rectValid && !rectReady |=> rectValid && $stable(rectY) && $stable(rectH));

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: no rectangle is offered together with done
  a_r9_done_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !rectValid);

  // R3: rectangle height is a nonzero whole number of bands
  a_r3_rect_shape: assert property (@(posedge clk) disable iff (!rstN)
    rectValid |-> (rectH != '0) && ((int'(rectH) % LINES_PER_BAND) == 0) &&
                  ((int'(rectY) % LINES_PER_BAND) == 0));

  // R3: rectangle stays inside the tracked screen
  a_r3_rect_bound: assert property (@(posedge clk) disable iff (!rstN)
    rectValid |-> (int'(rectY) + int'(rectH)) <= NUM_BANDS * LINES_PER_BAND);

  // R10: nothing is offered in the first cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !rectValid && !done);

endmodule

bind dirty_band_tracker dirty_band_tracker_checker #(
  .NUM_BANDS     (NUM_BANDS),
  .LINES_PER_BAND(LINES_PER_BAND),
  .LINE_W        (LINE_W)
) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .rectValid(rectValid),
  .rectReady(rectReady),
  .rectY    (rectY),
  .rectH    (rectH),
  .done     (done)
);

// File: tb/test_dirty_band_tracker.sv
module test_dirty_band_tracker;

  localparam int NB     = 8;
  localparam int LPB    = 4;
  localparam int AW     = 10;
  localparam int PS     = 4;
  localparam int LW     = $clog2(NB * LPB + 1);
  localparam int DEEPN  = NB * 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          snoopValid = 1'b0;
  logic [1:0]    snoopPlane = 2'd0;
  logic [AW-1:0] snoopAddr = '0;
  logic          invalidate = 1'b0;
  logic          deepMode = 1'b0;
  logic [LW-1:0] height = '0;
  logic          start = 1'b0;
  logic          rectValid;
  logic          rectReady = 1'b0;
  logic [LW-1:0] rectY, rectH;
  logic          done;

  int tests = 0;
  int fails = 0;

  bit mIdx[NB];
  bit mDir[DEEPN];
  bit mCtl[DEEPN];
  int expY[NB];
  int expH[NB];
  int expCnt;
  int expMin, expMax;
  bit expAny;

  always #5 clk = ~clk;

  dirty_band_tracker #(
    .NUM_BANDS(NB), .LINES_PER_BAND(LPB), .ADDR_W(AW), .PAGE_SHIFT(PS)
  ) i_dirty_band_tracker (
    .clk(clk), .rstN(rstN), .snoopValid(snoopValid), .snoopPlane(snoopPlane),
    .snoopAddr(snoopAddr), .invalidate(invalidate), .deepMode(deepMode),
    .height(height), .start(start), .rectValid(rectValid), .rectReady(rectReady),
    .rectY(rectY), .rectH(rectH), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic void modelSnoop(input int plane, input int addr);
    int page = addr >> PS;
    if (plane == 0 && page < NB) mIdx[page] = 1'b1;
    if (plane == 1 && page < DEEPN) mDir[page] = 1'b1;
    if (plane == 2 && page < DEEPN) mCtl[page] = 1'b1;
  endfunction

  function automatic void computeExpected(input int h, input bit deep);
    int nb = (h + LPB - 1) / LPB;
    int rs = 0;
    bit inRun = 1'b0;
    if (nb > NB) nb = NB;
    expCnt = 0; expAny = 1'b0; expMin = 0; expMax = 0;
    for (int b = 0; b < nb; b++) begin
      bit d = mIdx[b];
      for (int s = 0; s < 4; s++)
        if (deep && (mDir[b*4+s] || mCtl[b*4+s])) d = 1'b1;
      if (d) begin
        if (!inRun) begin inRun = 1'b1; rs = b; end
        if (!expAny) expMin = b;
        expMax = b; expAny = 1'b1;
      end else if (inRun) begin
        expY[expCnt] = rs * LPB; expH[expCnt] = (b - rs) * LPB; expCnt++;
        inRun = 1'b0;
      end
    end
    if (inRun) begin
      expY[expCnt] = rs * LPB; expH[expCnt] = (nb - rs) * LPB; expCnt++;
    end
  endfunction

  function automatic void modelClear(input bit deep);
    if (!expAny) return;
    for (int b = expMin; b <= expMax; b++) begin
      mIdx[b] = 1'b0;
      if (deep)
        for (int s = 0; s < 4; s++) begin mDir[b*4+s] = 1'b0; mCtl[b*4+s] = 1'b0; end
    end
  endfunction

  task automatic doSnoop(input int plane, input int addr);
    @(negedge clk);
    snoopValid = 1'b1; snoopPlane = 2'(plane); snoopAddr = AW'(addr);
    @(negedge clk);
    snoopValid = 1'b0;
    modelSnoop(plane, addr);
  endtask

  task automatic doInvalidate();
    @(negedge clk);
    invalidate = 1'b1;
    @(negedge clk);
    invalidate = 1'b0;
    for (int i = 0; i < NB; i++) mIdx[i] = 1'b1;
    for (int i = 0; i < DEEPN; i++) begin mDir[i] = 1'b1; mCtl[i] = 1'b1; end
  endtask

  // readyPct: chance of taking an offered rectangle; stall: cycles the first
  // rectangle is held back (a stray start is sent during the stall);
  // colAddr >= 0: indexed write issued in the clear cycle
  task automatic runScan(input int h, input bit deep, input int readyPct,
                         input int stall, input int colAddr, input string tag);
    int k = 0;
    int guard = 0;
    int stallLeft = stall;
    int extraDone = 0;
    bit seenDone = 1'b0;
    computeExpected(h, deep);
    @(negedge clk);
    height = LW'(h); deepMode = deep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seenDone && guard < 2000) begin
      start = 1'b0;
      snoopValid = 1'b0;
      rectReady = 1'b0;
      if (rectValid) begin
        if (stallLeft > 0) begin
          // R7: held rectangle stays the same while not taken
          check(k < expCnt && rectY == LW'(expY[k]), {tag, " R7 held y"}, int'(rectY), expY[k]);
          check(k < expCnt && rectH == LW'(expH[k]), {tag, " R7 held h"}, int'(rectH), expH[k]);
          if (stallLeft == 2) start = 1'b1;
          stallLeft--;
        end else if ($urandom_range(99) < readyPct) begin
          rectReady = 1'b1;
          check(k < expCnt, {tag, " R3 extra rect"}, k, expCnt);
          if (k < expCnt) begin
            check(rectY == LW'(expY[k]), {tag, " R3 rect y"}, int'(rectY), expY[k]);
            check(rectH == LW'(expH[k]), {tag, " R3 rect h"}, int'(rectH), expH[k]);
          end
          k++;
        end
      end
      if (done) begin
        seenDone = 1'b1;
        if (colAddr >= 0) begin
          snoopValid = 1'b1; snoopPlane = 2'd0; snoopAddr = AW'(colAddr);
        end
      end
      @(negedge clk);
      guard++;
    end
    snoopValid = 1'b0; rectReady = 1'b0; start = 1'b0;
    check(seenDone, {tag, " R9 done seen"}, int'(seenDone), 1);
    check(k == expCnt, {tag, " R3 rect count"}, k, expCnt);
    modelClear(deep);
    if (colAddr >= 0) modelSnoop(0, colAddr);
    for (int i = 0; i < 4; i++) begin
      if (done || rectValid) extraDone++;
      @(negedge clk);
    end
    check(extraDone == 0, {tag, " R9 single walk"}, extraDone, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: quiet outputs and clean flags after reset
    check(rectValid == 1'b0, "R10 rectValid after reset", int'(rectValid), 0);
    check(done == 1'b0, "R10 done after reset", int'(done), 0);
    runScan(32, 1'b1, 100, 0, -1, "R10 clean scan");

    // R1: indexed write to band 2 -> rectangle at line 8
    doSnoop(0, 2 << PS);
    runScan(32, 1'b0, 100, 0, -1, "R1 indexed");
    // R1: plane 3 and out-of-range page do nothing
    doSnoop(3, 1 << PS);
    doSnoop(0, 9 << PS);
    runScan(32, 1'b1, 100, 0, -1, "R1 ignored writes");
    // R4: direct page 13 (band 3) counts only in deep mode
    doSnoop(1, 13 << PS);
    runScan(32, 1'b0, 100, 0, -1, "R4 shallow");
    runScan(32, 1'b1, 100, 0, -1, "R4 deep");
    doSnoop(2, 31 << PS);
    runScan(32, 1'b1, 100, 0, -1, "R4 control last band");

    // R6 / R2: invalidate then odd height, then remainder
    doInvalidate();
    runScan(10, 1'b0, 100, 0, -1, "R2 R6 height 10");
    runScan(40, 1'b0, 100, 0, -1, "R2 clamp height");
    runScan(32, 1'b1, 100, 0, -1, "R6 deep rest");

    // R5: two runs with a clean gap; gap cleared as a range
    doSnoop(0, 1 << PS);
    doSnoop(0, 5 << PS);
    runScan(32, 1'b0, 100, 0, -1, "R5 two runs");
    runScan(32, 1'b0, 100, 0, -1, "R5 after clear");

    // R7 / R9: stalled rectangle with a stray start
    doSnoop(0, 0);
    doSnoop(0, 7 << PS);
    runScan(32, 1'b0, 100, 6, -1, "R7 stall");

    // R8: write in the clear cycle survives
    doSnoop(0, 4 << PS);
    runScan(32, 1'b0, 100, 0, 4 << PS, "R8 collide");
    runScan(32, 1'b0, 100, 0, -1, "R8 survivor");

    // random mix
    for (int it = 0; it < 60; it++) begin
      int n = $urandom_range(6);
      if ($urandom_range(9) == 0) doInvalidate();
      for (int j = 0; j < n; j++)
        doSnoop($urandom_range(3), $urandom_range(1023));
      runScan($urandom_range(40), 1'($urandom_range(1)), 30 + $urandom_range(70),
              0, -1, "R3 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule